// File: doc/BRIEF.md
# CPU Clock Stop Gate

This block sits between a free-running internal CPU clock and the output drivers. It passes or blocks the CPU clock as a true/complement pair, and drives a bank of identical enables for the SDRAM clock lanes that follow the CPU clock. An active-low stop request and an active-high power-down override arrive asynchronously. Each goes through its own multi-flop synchronizer clocked by the CPU clock before it can affect any output.

The gate for the true output is re-timed on the falling clock edge, and the gate for the complement is re-timed on the rising edge. Each gate therefore changes only while the output it controls is already low. Stopping parks every output low. Restarting always begins with a complete high pulse. Power-down wins over the stop request, and while power-down is active the stop request has no effect. Clock outputs that are not fed through this gate are never touched.

Top module: `cpu_clk_stop_gate`

## Requirements
- R1: While reset is asserted, and after reset until the synchronized stop request reads high with power-down low, `cpu_clk_t`, `cpu_clk_c` and every bit of `sdram_clk_en` are 0. After a reset release, with the inputs already in the run state, the first true high pulse begins on the second rising edge after the first rising edge that samples the release (default two synchronizer stages).
- R2: After `stop_n` falls, let P0 be the first rising edge that samples it low. The true high phases that begin at P0 and P1 are still full pulses. No true high phase begins from P2 onward. The complement pulses in the low phases after P0 and P1, and has no pulse from the low phase after P2. `sdram_clk_en` is all ones at P1 and all zeros from P2 onward.
- R3: After `stop_n` rises with power-down low, counting edges as in R2, the first true high pulse begins at P2 and the first complement pulse follows P2. `sdram_clk_en` becomes all ones by P2. Both the on latency and the off latency stay below 4 CPU cycles for every legal synchronizer depth (2 or 3).
- R4: No output pulse is ever shortened. The true gate enable is constant across each high phase of `clk_cpu`, and the complement gate enable is constant across each low phase.
- R5: When `pwr_dn` is 1, all outputs go low with the same latency as R2 and stay low whatever `stop_n` does.
- R6: All bits of `sdram_clk_en` are equal at all times. They are 1 exactly during the half cycles in which the true output is allowed to pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Free-running internal CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Asynchronous active-low CPU clock stop request |
| pwr_dn | input | 1 | Asynchronous active-high power-down override |
| cpu_clk_t | output | 1 | Gated true CPU clock, parks low |
| cpu_clk_c | output | 1 | Gated complement CPU clock, parks low |
| sdram_clk_en | output | SDRAM_LANES | Per-lane SDRAM clock enables, all equal |

## Verification
The bound checker checks on every cycle that the stop and power-down latencies hold at both polarities of the pair (using its own saturating counters of input history), that each gate enable stays constant across the clock phase it guards, and that the lane enables match the true gate. Only the bench scenarios show the behaviour tied to sequence: parking after reset until the request has passed through the synchronizer, the exact cycle-by-cycle entry into and exit from the stopped state, and stop toggling that is ignored under power-down. A phase monitor in the bench also watches every high and low phase for runt pulses.

// File: rtl/cpugate_pkg.sv
package cpugate_pkg;

   // Latency bound on the stop path, in CPU cycles; the synchronizer plus
   // one half-cycle re-time stage must stay below it.
   localparam int unsigned LATENCY_LIMIT = 4;
   localparam int unsigned SYNC_MIN      = 2;
   localparam int unsigned SYNC_MAX      = LATENCY_LIMIT - 1;

   typedef enum logic {
      GATE_PARKED  = 1'b0,
      GATE_RUNNING = 1'b1
   } gate_state_e;

   // Run only when the stop request is released and power-down is off.
   function automatic gate_state_e run_decision(input logic stop_rel,
                                                input logic pd_active);
      return (stop_rel && !pd_active) ? GATE_RUNNING : GATE_PARKED;
   endfunction

endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q
);

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/cg_gate_ctrl.sv
module cg_gate_ctrl
   import cpugate_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  gate_state_e run_req,
   output logic        en_t,
   output logic        en_c
);

   gate_state_e state_t;
   gate_state_e state_c;

   // True gate: re-timed while the clock is low, so the AND gate never cuts
   // a high phase.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) state_t <= GATE_PARKED;
      else        state_t <= run_req;
   end

   // Complement gate: follows half a cycle later, re-timed while the
   // inverted clock is low.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_c <= GATE_PARKED;
      else        state_c <= state_t;
   end

   assign en_t = (state_t == GATE_RUNNING);
   assign en_c = (state_c == GATE_RUNNING);

endmodule

// File: rtl/cg_lane_fanout.sv
module cg_lane_fanout
   import cpugate_pkg::*;
#(
   parameter int unsigned LANES = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  gate_state_e      run_req,
   output logic [LANES-1:0] lane_en
);

   // One replica flop per lane keeps each enable local to its driver.
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) lane_en[l] <= 1'b0;
         else        lane_en[l] <= (run_req == GATE_RUNNING);
      end
   end

endmodule

// File: rtl/cpu_clk_stop_gate.sv
module cpu_clk_stop_gate
   import cpugate_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SDRAM_LANES = 12
) (
   input  logic                   clk_cpu,
   input  logic                   rst_n,
   input  logic                   stop_n,
   input  logic                   pwr_dn,
   output logic                   cpu_clk_t,
   output logic                   cpu_clk_c,
   output logic [SDRAM_LANES-1:0] sdram_clk_en
);

   if (SYNC_STAGES < SYNC_MIN || SYNC_STAGES > SYNC_MAX) begin : g_bad_sync
      $error("cpu_clk_stop_gate: SYNC_STAGES %0d breaks the latency bound",
             SYNC_STAGES);
   end
   if (SDRAM_LANES < 1) begin : g_bad_lanes
      $error("cpu_clk_stop_gate: SDRAM_LANES must be at least 1");
   end

   logic        stop_rel_s;
   logic        pd_s;
   gate_state_e run_req;
   logic        en_t;
   logic        en_c;

   // Reset values both mean "parked".
   cg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_stop (
      .clk(clk_cpu), .rst_n(rst_n), .d_async(stop_n), .q(stop_rel_s)
   );

   cg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pd (
      .clk(clk_cpu), .rst_n(rst_n), .d_async(pwr_dn), .q(pd_s)
   );

   assign run_req = run_decision(stop_rel_s, pd_s);

   cg_gate_ctrl u_ctrl (
      .clk(clk_cpu), .rst_n(rst_n), .run_req(run_req),
      .en_t(en_t), .en_c(en_c)
   );

   cg_lane_fanout #(.LANES(SDRAM_LANES)) u_lanes (
      .clk(clk_cpu), .rst_n(rst_n), .run_req(run_req), .lane_en(sdram_clk_en)
   );

   assign cpu_clk_t = clk_cpu & en_t;
   assign cpu_clk_c = ~clk_cpu & en_c;

endmodule

// File: rtl/cg_gate_chk.sv
module cg_gate_chk #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned LANES  = 12
) (
   input logic             clk_cpu,
   input logic             rst_n,
   input logic             stop_n,
   input logic             pwr_dn,
   input logic             cpu_clk_t,
   input logic             cpu_clk_c,
   input logic [LANES-1:0] sdram_clk_en,
   input logic             en_t,
   input logic             en_c
);

   localparam int unsigned CW  = $clog2(STAGES + 2);
   localparam logic [CW-1:0] SAT = CW'(STAGES + 1);
   localparam logic [CW-1:0] NT  = CW'(STAGES);
   localparam logic [CW-1:0] NC  = CW'(STAGES + 1);

   function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
      return (v == SAT) ? v : v + 1'b1;
   endfunction

   // Saturating history counters, one set per clock edge.
   logic [CW-1:0] stop_n_cnt, pd_n_cnt, run_n_cnt;
   logic [CW-1:0] stop_p_cnt, pd_p_cnt, run_p_cnt;
   logic          t_hold, c_hold;

   always_ff @(negedge clk_cpu or negedge rst_n) begin
      if (!rst_n) begin
         stop_n_cnt <= '0; pd_n_cnt <= '0; run_n_cnt <= '0; c_hold <= 1'b0;
      end else begin
         stop_n_cnt <= !stop_n ? bump(stop_n_cnt) : '0;
         pd_n_cnt   <= pwr_dn ? bump(pd_n_cnt) : '0;
         run_n_cnt  <= (stop_n && !pwr_dn) ? bump(run_n_cnt) : '0;
         c_hold     <= en_c;
      end
   end

   always_ff @(posedge clk_cpu or negedge rst_n) begin
      if (!rst_n) begin
         stop_p_cnt <= '0; pd_p_cnt <= '0; run_p_cnt <= '0; t_hold <= 1'b0;
      end else begin
         stop_p_cnt <= !stop_n ? bump(stop_p_cnt) : '0;
         pd_p_cnt   <= pwr_dn ? bump(pd_p_cnt) : '0;
         run_p_cnt  <= (stop_n && !pwr_dn) ? bump(run_p_cnt) : '0;
         t_hold     <= en_t;
      end
   end

   // Sampled at a falling edge, cpu_clk_t shows the high phase just ended.
   p_true_off_r2: assert property (@(negedge clk_cpu) disable iff (!rst_n)
      (stop_n_cnt >= NT) |-> !cpu_clk_t);
   p_true_on_r3: assert property (@(negedge clk_cpu) disable iff (!rst_n)
      (run_n_cnt >= NT) |-> cpu_clk_t);
   // Sampled at a rising edge, cpu_clk_c shows the low phase just ended.
   p_comp_off_r2: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      (stop_p_cnt >= NC) |-> !cpu_clk_c);
   p_comp_on_r3: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      (run_p_cnt >= NC) |-> cpu_clk_c);
   p_pd_true_r5: assert property (@(negedge clk_cpu) disable iff (!rst_n)
      (pd_n_cnt >= NT) |-> !cpu_clk_t);
   p_pd_comp_r5: assert property (@(posedge clk_cpu) disable iff (!rst_n)
      (pd_p_cnt >= NC) |-> !cpu_clk_c);
   p_lanes_track_r6: assert property (@(negedge clk_cpu) disable iff (!rst_n)
      sdram_clk_en == (cpu_clk_t ? {LANES{1'b1}} : {LANES{1'b0}}));

   // Gate enables may only move while their output is low.
   always @(negedge clk_cpu) begin
      if (rst_n) begin
         p_true_steady_r4: assert (en_t == t_hold)
            else $error("true gate enable moved during a high phase");
      end
   end

   always @(posedge clk_cpu) begin
      if (rst_n) begin
         p_comp_steady_r4: assert (en_c == c_hold)
            else $error("complement gate enable moved during a low phase");
      end
   end

endmodule

bind cpu_clk_stop_gate cg_gate_chk #(
   .STAGES(SYNC_STAGES), .LANES(SDRAM_LANES)
) u_chk (
   .clk_cpu(clk_cpu), .rst_n(rst_n), .stop_n(stop_n), .pwr_dn(pwr_dn),
   .cpu_clk_t(cpu_clk_t), .cpu_clk_c(cpu_clk_c),
   .sdram_clk_en(sdram_clk_en), .en_t(en_t), .en_c(en_c)
);

// File: tb/sim_cpu_clk_stop_gate.sv
module sim_cpu_clk_stop_gate;

   localparam int LANES = 12;
   localparam int NV    = 7;
   // Vector fields: {stop_n, pwr_dn, expect_running, hold_cycles[6:0]}
   localparam logic [9:0] VEC [NV] = '{
      {1'b0, 1'b0, 1'b0, 7'd12},
      {1'b1, 1'b0, 1'b1, 7'd105},
      {1'b1, 1'b1, 1'b0, 7'd10},
      {1'b0, 1'b1, 1'b0, 7'd10},
      {1'b0, 1'b0, 1'b0, 7'd8},
      {1'b1, 1'b0, 1'b1, 7'd102},
      {1'b0, 1'b0, 1'b0, 7'd6}
   };

   logic clk = 1'b0;
   logic rst_n, stop_n, pwr_dn;
   logic cpu_clk_t, cpu_clk_c;
   logic [LANES-1:0] sdram_clk_en;
   int checks = 0;
   int fails  = 0;
   int runts  = 0;
   int pulses = 0;

   always #5 clk = ~clk;

   cpu_clk_stop_gate #(.SYNC_STAGES(2), .SDRAM_LANES(LANES)) u0 (
      .clk_cpu(clk), .rst_n(rst_n), .stop_n(stop_n), .pwr_dn(pwr_dn),
      .cpu_clk_t(cpu_clk_t), .cpu_clk_c(cpu_clk_c), .sdram_clk_en(sdram_clk_en)
   );

   // Phase monitors for R4: an output must hold one value across a phase.
   always @(posedge clk) begin
      logic a;
      #1 a = cpu_clk_t;
      #3 if (cpu_clk_t !== a) runts++;
      if (a === 1'b1) pulses++;
   end
   always @(negedge clk) begin
      logic a;
      #1 a = cpu_clk_c;
      #3 if (cpu_clk_c !== a) runts++;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic at_neg();
      @(negedge clk); #1;
   endtask

   task automatic sample_cycle(output logic t, output logic c,
                               output logic [LANES-1:0] s);
      @(posedge clk); #2; t = cpu_clk_t; s = sdram_clk_en;
      @(negedge clk); #2; c = cpu_clk_c;
   endtask

   // Checks three cycles after an input change made just after a falling edge.
   task automatic latency_seq(input string req, input logic [2:0] exp_seq);
      logic t, c;
      logic [LANES-1:0] s;
      for (int k = 0; k < 3; k++) begin
         sample_cycle(t, c, s);
         chk(req, $sformatf("true cycle %0d", k), 32'(t), 32'(exp_seq[k]));
         chk(req, $sformatf("comp cycle %0d", k), 32'(c), 32'(exp_seq[k]));
         chk(req, $sformatf("lanes cycle %0d", k), 32'(s),
             32'(exp_seq[k] ? {LANES{1'b1}} : {LANES{1'b0}}));
      end
   endtask

   initial begin
      #2000000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic t, c;
      logic [LANES-1:0] s;
      rst_n = 1'b0; stop_n = 1'b1; pwr_dn = 1'b0;
      repeat (3) @(posedge clk);
      sample_cycle(t, c, s);
      chk("R1", "true in reset", 32'(t), 0);
      chk("R1", "comp in reset", 32'(c), 0);
      chk("R1", "lanes in reset", 32'(s), 0);
      at_neg(); rst_n = 1'b1;
      latency_seq("R1", 3'b100);
      repeat (105) @(posedge clk);

      // Vector walk (R2, R3, R5, R6)
      for (int v = 0; v < NV; v++) begin
         string req;
         at_neg();
         stop_n = VEC[v][9]; pwr_dn = VEC[v][8];
         repeat (int'(VEC[v][6:0]) - 1) @(posedge clk);
         sample_cycle(t, c, s);
         req = VEC[v][8] ? "R5" : (VEC[v][7] ? "R3" : "R2");
         chk(req, $sformatf("vec %0d true", v), 32'(t), 32'(VEC[v][7]));
         chk(req, $sformatf("vec %0d comp", v), 32'(c), 32'(VEC[v][7]));
         chk("R6", $sformatf("vec %0d lanes", v), 32'(s),
             32'(VEC[v][7] ? {LANES{1'b1}} : {LANES{1'b0}}));
      end

      // Exact restart and stop timing
      at_neg(); stop_n = 1'b1;
      latency_seq("R3", 3'b100);
      repeat (100) @(posedge clk);
      at_neg(); stop_n = 1'b0;
      latency_seq("R2", 3'b011);
      repeat (5) @(posedge clk);
      at_neg(); stop_n = 1'b1;
      latency_seq("R3", 3'b100);
      repeat (100) @(posedge clk);

      // Power-down overrides and ignores the stop request
      at_neg(); pwr_dn = 1'b1;
      latency_seq("R5", 3'b011);
      for (int k = 0; k < 8; k++) begin
         at_neg(); stop_n = ~stop_n;
         sample_cycle(t, c, s);
         chk("R5", $sformatf("true, stop toggle %0d", k), 32'(t), 0);
         chk("R5", $sformatf("comp, stop toggle %0d", k), 32'(c), 0);
      end
      at_neg(); stop_n = 1'b1; pwr_dn = 1'b0;
      latency_seq("R3", 3'b100);
      repeat (100) @(posedge clk);

      // Reset while stopped, released with the stop request still low
      at_neg(); stop_n = 1'b0;
      repeat (5) @(posedge clk);
      at_neg(); rst_n = 1'b0;
      #1;
      chk("R1", "lanes at reset", 32'(sdram_clk_en), 0);
      repeat (3) @(posedge clk);
      at_neg(); rst_n = 1'b1;
      repeat (20) @(posedge clk);
      sample_cycle(t, c, s);
      chk("R1", "true parked after reset", 32'(t), 0);
      chk("R1", "comp parked after reset", 32'(c), 0);
      chk("R1", "lanes parked after reset", 32'(s), 0);
      at_neg(); stop_n = 1'b1;
      latency_seq("R1", 3'b100);
      repeat (10) @(posedge clk);

      chk("R4", "runt phases", 32'(runts), 0);
      chk("R4", "pulses seen", 32'(pulses > 100), 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule